// File: doc/BRIEF.md
# Triggered Instruction Priority Scheduler

This block decides, every clock cycle, which instruction of a small, statically programmed pool is allowed to issue. There is no program counter. Each of the 16 pool slots holds a guard, and all guards are tested in parallel against the current state. That state is a set of eight one-bit predicates, the occupancy and head tags of four input queues, and the free space of four output queues. A fixed priority order then selects one slot among those whose guards pass.

The slot guards live in registers and are loaded through a simple configuration write port that carries a slot index, a 32-bit guard word and a write enable. A write takes effect at the next clock edge. The outputs are combinational from the registered guards and the live state: an issue-valid flag and the number of the chosen slot. The datapath, operand fetch and queue storage sit outside this block.

Guard word layout (bit positions): [31] valid, [30:23] predicate must-be-one mask, [22:15] predicate must-be-zero mask, [14:12] second queue check index, [11:9] first queue check index, [8:7] second reference tag, [6:5] first reference tag, [4] second check inversion, [3] first check inversion, [2] destination-is-output-queue flag, [1:0] destination output queue number.

Top module: `tis_sched`

## Requirements
- R1: Synchronous active-high reset clears every slot's guard word to zero, so right after reset no slot can issue.
- R2: A slot whose valid bit (guard bit 31) is 0 is never selected, whatever its other fields hold.
- R3: When several slots are eligible, the one with the lowest slot number is selected.
- R4: The predicate test passes only when every predicate whose must-be-one mask bit (guard bits 30:23, bit n of the mask for predicate n) is set reads 1 and every predicate whose must-be-zero mask bit (guard bits 22:15) is set reads 0; predicates set in neither mask do not matter.
- R5: Each of the two queue checks has a 3-bit index field (bits 11:9 and 14:12). A value of 0 to 3 names an input queue, which must be non-empty and whose head tag (input bits 2q+1:2q) must equal the 2-bit reference tag (bits 6:5 and 8:7). A value with its top bit set (4 to 7) disables the check so that it always passes.
- R6: A set inversion bit (bit 3 for the first check, bit 4 for the second) makes the check pass when the named queue is non-empty and its head tag differs from the reference tag.
- R7: When the destination flag (bit 2) is 1, the slot is eligible only if the output queue numbered by bits 1:0 has space; when the flag is 0, output queue space is ignored.
- R8: A guard written through the configuration port is used from the clock edge that accepts it; during the cycle in which a slot is being written, that slot is treated as not eligible.
- R9: When no slot is eligible, issue-valid is 0 and the issued index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Guard write enable |
| cfg_idx | input | 4 | Slot number being written |
| cfg_data | input | 32 | Guard word to write |
| pred | input | 8 | Current predicate bits |
| iq_nempty | input | 4 | Input queue n holds data (bit n) |
| iq_tag | input | 8 | Head tag of input queue n at bits 2n+1:2n |
| oq_space | input | 4 | Output queue n can accept a word (bit n) |
| issue_vld | output | 1 | A slot is selected this cycle |
| issue_idx | output | 4 | Selected slot number, 0 when idle |

## Verification
On every cycle, the assertions check that any issued slot is valid, meets its predicate masks, and is not being written in that cycle. They also check that no lower-numbered slot was eligible at the same time, that the idle index is zero, and that nothing issues right after reset. How each guard field decodes must be shown by the directed scenarios, because the checker accepts whichever eligibility the guard logic reports. These fields are the queue check codes, the tag comparison and its inversion, and the output-space condition.

// File: rtl/tis_pkg.sv
package tis_pkg;
    localparam int N_SLOT = 16;
    localparam int N_PRED = 8;
    localparam int N_IQ   = 4;
    localparam int N_OQ   = 4;
    localparam int N_CHK  = 2;
    localparam int TAG_W  = 2;
    localparam int IDX_W  = $clog2(N_SLOT);
    localparam int IQ_W   = $clog2(N_IQ);
    localparam int OQ_W   = $clog2(N_OQ);
    localparam int QSEL_W = IQ_W + 1;

    typedef struct packed {
        logic                          valid;
        logic [N_PRED-1:0]             must_one;
        logic [N_PRED-1:0]             must_zero;
        logic [N_CHK-1:0][QSEL_W-1:0]  chk_q;
        logic [N_CHK-1:0][TAG_W-1:0]   chk_tag;
        logic [N_CHK-1:0]              chk_inv;
        logic                          dst_oq;
        logic [OQ_W-1:0]               dst_q;
    } guard_t;

    localparam int GUARD_W = $bits(guard_t);

    function automatic logic pred_match(guard_t g, logic [N_PRED-1:0] p);
        return (&(~g.must_one | p)) && (&(~g.must_zero | ~p));
    endfunction
endpackage

// File: rtl/tis_guard_store.sv
module tis_guard_store
    import tis_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  guard_t                 cfg_data,
    output guard_t [N_SLOT-1:0]    slots,
    output logic   [N_SLOT-1:0]    busy
);
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        logic hit;
        assign hit     = cfg_we && (cfg_idx == IDX_W'(s));
        assign busy[s] = hit;
        always_ff @(posedge clk) begin
            if (rst)      slots[s] <= '0;
            else if (hit) slots[s] <= cfg_data;
        end
    end
endmodule

// File: rtl/tis_guard_eval.sv
module tis_guard_eval
    import tis_pkg::*;
(
    input  guard_t                        g,
    input  logic                          blocked,
    input  logic [N_PRED-1:0]             pred,
    input  logic [N_IQ-1:0]               iq_nempty,
    input  logic [N_IQ-1:0][TAG_W-1:0]    iq_tag,
    input  logic [N_OQ-1:0]               oq_space,
    output logic                          elig
);
    logic [N_CHK-1:0] chk_ok;

    for (genvar k = 0; k < N_CHK; k++) begin : g_chk
        logic            off;
        logic [IQ_W-1:0] q;
        logic            same;
        assign off  = g.chk_q[k][QSEL_W-1];
        assign q    = g.chk_q[k][IQ_W-1:0];
        assign same = (iq_tag[q] == g.chk_tag[k]);
        assign chk_ok[k] = off || (iq_nempty[q] && (same ^ g.chk_inv[k]));
    end

    logic dst_ok;
    assign dst_ok = !g.dst_oq || oq_space[g.dst_q];

    assign elig = g.valid && !blocked && pred_match(g, pred) && (&chk_ok) && dst_ok;
endmodule

// File: rtl/tis_prio_pick.sv
module tis_prio_pick
    import tis_pkg::*;
(
    input  logic [N_SLOT-1:0] req,
    output logic              vld,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = N_SLOT - 1; i >= 0; i--) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tis_sched.sv
module tis_sched
    import tis_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [GUARD_W-1:0]        cfg_data,
    input  logic [N_PRED-1:0]         pred,
    input  logic [N_IQ-1:0]           iq_nempty,
    input  logic [N_IQ*TAG_W-1:0]     iq_tag,
    input  logic [N_OQ-1:0]           oq_space,
    output logic                      issue_vld,
    output logic [IDX_W-1:0]          issue_idx
);
    guard_t [N_SLOT-1:0]             slots;
    logic   [N_SLOT-1:0]             busy;
    logic   [N_SLOT-1:0]             elig;
    logic   [N_IQ-1:0][TAG_W-1:0]    tags;

    assign tags = iq_tag;

    tis_guard_store u_store (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_data (guard_t'(cfg_data)),
        .slots    (slots),
        .busy     (busy)
    );

    for (genvar s = 0; s < N_SLOT; s++) begin : g_eval
        tis_guard_eval u_eval (
            .g         (slots[s]),
            .blocked   (busy[s]),
            .pred      (pred),
            .iq_nempty (iq_nempty),
            .iq_tag    (tags),
            .oq_space  (oq_space),
            .elig      (elig[s])
        );
    end

    tis_prio_pick u_pick (
        .req (elig),
        .vld (issue_vld),
        .idx (issue_idx)
    );
endmodule

// File: rtl/tis_sched_chk.sv
module tis_sched_chk
    import tis_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [N_PRED-1:0]      pred,
    input  guard_t [N_SLOT-1:0]    slots,
    input  logic [N_SLOT-1:0]      elig,
    input  logic                   issue_vld,
    input  logic [IDX_W-1:0]       issue_idx
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !issue_vld);

    assert_issued_valid_R2: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> slots[issue_idx].valid);

    assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> ((elig & ((N_SLOT'(1) << issue_idx) - N_SLOT'(1))) == '0));

    assert_pred_masks_R4: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> (((slots[issue_idx].must_one & ~pred) == '0) &&
                       ((slots[issue_idx].must_zero & pred) == '0)));

    assert_no_issue_while_written_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && cfg_we) |-> (cfg_idx != issue_idx));

    assert_idle_index_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !issue_vld |-> (issue_idx == '0));

    assert_idle_iff_none_R9: assert property (@(posedge clk) disable iff (rst)
        issue_vld == (elig != '0));
endmodule

bind tis_sched tis_sched_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .pred      (pred),
    .slots     (slots),
    .elig      (elig),
    .issue_vld (issue_vld),
    .issue_idx (issue_idx)
);

// File: tb/tis_sched_tb_top.sv
module tis_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [31:0] cfg_data;
    logic [7:0]  pred;
    logic [3:0]  iq_nempty;
    logic [7:0]  iq_tag;
    logic [3:0]  oq_space;
    logic        issue_vld;
    logic [3:0]  issue_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tis_sched dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .pred(pred), .iq_nempty(iq_nempty), .iq_tag(iq_tag), .oq_space(oq_space),
        .issue_vld(issue_vld), .issue_idx(issue_idx)
    );

    localparam logic [2:0] QNONE = 3'd4;

    function automatic logic [31:0] mk(logic v, logic [7:0] one, logic [7:0] zero,
                                       logic [2:0] q1, logic [2:0] q0,
                                       logic [1:0] t1, logic [1:0] t0,
                                       logic i1, logic i0, logic doq, logic [1:0] dq);
        return {v, one, zero, q1, q0, t1, t0, i1, i0, doq, dq};
    endfunction

    function automatic logic [31:0] always_on();
        return mk(1'b1, 8'h00, 8'h00, QNONE, QNONE, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    endfunction

    task automatic check(string req, logic ev, logic [3:0] ei);
        #2;
        n_chk++;
        if (issue_vld !== ev || issue_idx !== ei) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b idx=%0d, expected vld=%0b idx=%0d",
                     req, issue_vld, issue_idx, ev, ei);
        end
    endtask

    task automatic wr(logic [3:0] idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int s = 0; s < 16; s++) wr(4'(s), 32'h0);
        pred = 8'h00; iq_nempty = 4'h0; iq_tag = 8'h00; oq_space = 4'h0;
    endtask

    task automatic t_reset();
        check("R1", 1'b0, 4'd0);
        check("R9", 1'b0, 4'd0);
    endtask

    task automatic t_valid_bit();
        clear_all();
        wr(4'd5, always_on() & 32'h7FFF_FFFF);
        check("R2", 1'b0, 4'd0);
        wr(4'd5, always_on());
        check("R2", 1'b1, 4'd5);
    endtask

    task automatic t_priority();
        clear_all();
        wr(4'd9, always_on());
        wr(4'd5, always_on());
        check("R3", 1'b1, 4'd5);
        wr(4'd2, always_on());
        check("R3", 1'b1, 4'd2);
        wr(4'd15, always_on());
        check("R3", 1'b1, 4'd2);
    endtask

    task automatic t_predicates();
        clear_all();
        wr(4'd3, mk(1'b1, 8'h81, 8'h02, QNONE, QNONE, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0));
        pred = 8'h81; check("R4", 1'b1, 4'd3);
        pred = 8'h83; check("R4", 1'b0, 4'd0);
        pred = 8'h80; check("R4", 1'b0, 4'd0);
        pred = 8'hF1; check("R4", 1'b1, 4'd3);
    endtask

    task automatic t_queues();
        clear_all();
        wr(4'd4, mk(1'b1, 8'h00, 8'h00, 3'd7, 3'd2, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0));
        iq_nempty = 4'b0100; iq_tag = 8'b00_01_00_00; check("R5", 1'b1, 4'd4);
        iq_nempty = 4'b1011;                          check("R5", 1'b0, 4'd0);
        iq_nempty = 4'b0100; iq_tag = 8'b00_10_00_00; check("R5", 1'b0, 4'd0);
        wr(4'd4, mk(1'b1, 8'h00, 8'h00, 3'd1, 3'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0));
        iq_nempty = 4'b0011; iq_tag = 8'b00_00_00_11; check("R5", 1'b1, 4'd4);
        iq_nempty = 4'b0001;                          check("R5", 1'b0, 4'd0);
    endtask

    task automatic t_invert();
        clear_all();
        wr(4'd7, mk(1'b1, 8'h00, 8'h00, QNONE, 3'd2, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0));
        iq_nempty = 4'b0100; iq_tag = 8'b00_01_00_00; check("R6", 1'b0, 4'd0);
        iq_tag = 8'b00_11_00_00;                      check("R6", 1'b1, 4'd7);
        iq_nempty = 4'b0000;                          check("R6", 1'b0, 4'd0);
    endtask

    task automatic t_outq();
        clear_all();
        wr(4'd10, mk(1'b1, 8'h00, 8'h00, QNONE, QNONE, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd3));
        oq_space = 4'b0111; check("R7", 1'b0, 4'd0);
        oq_space = 4'b1000; check("R7", 1'b1, 4'd10);
        wr(4'd10, mk(1'b1, 8'h00, 8'h00, QNONE, QNONE, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3));
        oq_space = 4'b0000; check("R7", 1'b1, 4'd10);
    endtask

    task automatic t_write_hazard();
        clear_all();
        wr(4'd6, always_on());
        wr(4'd1, always_on());
        check("R8", 1'b1, 4'd1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'd1; cfg_data = always_on();
        check("R8", 1'b1, 4'd6);
        @(negedge clk);
        cfg_we = 1'b0;
        check("R8", 1'b1, 4'd1);
        wr(4'd1, 32'h0);
        check("R8", 1'b1, 4'd6);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
        pred = '0; iq_nempty = '0; iq_tag = '0; oq_space = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_valid_bit();
        t_priority();
        t_predicates();
        t_queues();
        t_invert();
        t_outq();
        t_write_hazard();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule